// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Controller

This block moves a block of words from one peripheral into memory without the processor touching each word. The processor programs a start address, a word count and a mode through a small register port. When the peripheral asks for service, the controller requests the system bus and waits for the grant. It then acknowledges the peripheral, captures the word the peripheral puts out, and writes that word to memory at the current address. The address steps up by one for every word and the count steps down by one.

Two bus policies are available. In burst mode the controller holds the bus from the first word to the last, even across pauses in the peripheral's requests. In cycle-stealing mode it gives the bus back after every word and asks for it again for the next one. When the count reaches zero the controller releases the bus, disarms itself and raises an interrupt. The interrupt clears when the processor reads the status register or writes a new count. While the controller requests or holds the bus, the register port ignores every access.

Top module: `dma_engine`

## Requirements
- R1: After reset, bus_req, dev_ack, mem_wr, bus_drive and irq are low, and the address, count and mode registers read back as zero.
- R2: With cpu_cs high, cpu_wr writes the register chosen by cpu_rs (0 address, 1 count, 2 mode, 3 status, which is read-only), and cpu_rd returns the selected register on cpu_rdata one cycle later. The mode register has bit 0 set for burst and clear for cycle stealing, and bit 1 arms the channel. The status register has bit 0 showing the armed state and bit 1 showing the interrupt.
- R3: When the channel is armed with a non-zero count and dev_req is high, bus_req rises on the next clock edge. No dev_ack is given while bus_grant stays low.
- R4: One edge after bus_grant is seen, dev_ack is high for one cycle. In the next cycle mem_wr is high for one cycle. During that cycle mem_addr holds the address register's value and mem_wdata holds dev_data as it was at the end of the acknowledge cycle.
- R5: Each word raises the address register by one and lowers the count register by one. The new values can be read back after the transfer.
- R6: In burst mode bus_req stays high from the first request until the last word is written, including while dev_req is low between words, so a whole block needs one bus request.
- R7: In cycle-stealing mode bus_req falls in the cycle after each word's write, so a block of N words makes N separate bus requests.
- R8: In the cycle after the write of the last word, bus_req is low, irq is high and the arm bit is clear.
- R9: A read of the status register, or a write to the count register, clears irq.
- R10: While bus_req is high, register writes have no effect.
- R11: A channel armed with a count of zero never raises bus_req, even while dev_req is high.
- R12: bus_drive is high exactly in the acknowledge and write cycles of a word, and only while bus_grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cs | input | 1 | Register port select |
| cpu_rs | input | 2 | Register index |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Registered read data |
| irq | output | 1 | End-of-block interrupt |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Peripheral acknowledge |
| dev_data | input | DW | Word supplied by the peripheral |
| bus_drive | output | 1 | Enable for the controller's bus drivers |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_wr | output | 1 | Memory write strobe |

## Verification
A wrong address or count register shows up at the memory port on the very next word, because each word lands one address off or the block ends one word early or late. The bench finds this by comparing memory contents and reading back the registers after the block. A sequencer in the wrong state shows up within one or two cycles as a missing or extra acknowledge, a write without a preceding acknowledge, or a bus request that lingers or drops at the wrong time. To catch this, the bench counts bus-request rises per block and compares the cycle of the interrupt with the cycle of the last write. A lock that fails to block register writes in the middle of a block moves the later words to the wrong place, and the bench reports this when the block completes.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_MODE   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ACK  = 3'd2,
    ST_WR   = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;

  localparam int MODE_BURST_BIT  = 0;
  localparam int MODE_ARM_BIT    = 1;
  localparam int STATUS_ARM_BIT  = 0;
  localparam int STATUS_IRQ_BIT  = 1;

endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_cs,
  input  logic [1:0]    cpu_rs,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          bus_locked,
  input  logic          word_step,
  input  logic          xfer_end,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output logic          burst_q,
  output logic          arm_q,
  output logic          irq_q
);

  reg_sel_e      sel;
  logic          port_open;
  logic          wr_en;
  logic          rd_en;
  logic [DW-1:0] rd_mux;

  assign sel       = reg_sel_e'(cpu_rs);
  assign port_open = cpu_cs && !bus_locked;
  assign wr_en     = port_open && cpu_wr;
  assign rd_en     = port_open && cpu_rd && !cpu_wr;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_ADDR:   rd_mux[AW-1:0] = addr_q;
      SEL_COUNT:  rd_mux[CW-1:0] = count_q;
      SEL_MODE: begin
        rd_mux[MODE_BURST_BIT] = burst_q;
        rd_mux[MODE_ARM_BIT]   = arm_q;
      end
      SEL_STATUS: begin
        rd_mux[STATUS_ARM_BIT] = arm_q;
        rd_mux[STATUS_IRQ_BIT] = irq_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      count_q   <= '0;
      burst_q   <= 1'b0;
      arm_q     <= 1'b0;
      irq_q     <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (word_step) begin
        addr_q  <= addr_q + AW'(1);
        count_q <= count_q - CW'(1);
      end
      if (xfer_end) begin
        arm_q <= 1'b0;
        irq_q <= 1'b1;
      end
      if (wr_en) begin
        unique case (sel)
          SEL_ADDR:  addr_q <= cpu_wdata[AW-1:0];
          SEL_COUNT: begin
            count_q <= cpu_wdata[CW-1:0];
            irq_q   <= 1'b0;
          end
          SEL_MODE: begin
            burst_q <= cpu_wdata[MODE_BURST_BIT];
            arm_q   <= cpu_wdata[MODE_ARM_BIT];
          end
          default: ;
        endcase
      end
      if (rd_en) begin
        cpu_rdata <= rd_mux;
        if (sel == SEL_STATUS) irq_q <= 1'b0;
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    word_step |=> addr_q == $past(addr_q) + AW'(1)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    word_step |=> count_q == $past(count_q) - CW'(1)); // R5
  AST_END_FLAGS: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> irq_q && !arm_q); // R8
  AST_LOCKED_MODE: assert property (@(posedge clk) disable iff (rst)
    (bus_locked && cpu_cs && cpu_wr) |=> $stable(burst_q)); // R10

endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          burst,
  input  logic          count_zero,
  input  logic [AW-1:0] addr,
  input  logic          dev_req,
  input  logic          bus_grant,
  input  logic [DW-1:0] dev_data,
  output logic          bus_req,
  output logic          dev_ack,
  output logic          mem_wr,
  output logic          bus_drive,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          word_step,
  output logic          xfer_end
);

  seq_state_e st, st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (arm && !count_zero && dev_req) st_nxt = ST_REQ;
      ST_REQ:  if (bus_grant) st_nxt = ST_ACK;
      ST_ACK:  st_nxt = ST_WR;
      ST_WR: begin
        if (count_zero || !burst) st_nxt = ST_IDLE;
        else if (dev_req)         st_nxt = ST_ACK;
        else                      st_nxt = ST_HOLD;
      end
      ST_HOLD: if (dev_req) st_nxt = ST_ACK;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign word_step = (st == ST_ACK);
  assign xfer_end  = (st == ST_WR) && count_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_req   <= 1'b0;
      dev_ack   <= 1'b0;
      mem_wr    <= 1'b0;
      bus_drive <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      st        <= st_nxt;
      bus_req   <= (st_nxt != ST_IDLE);
      dev_ack   <= (st_nxt == ST_ACK);
      mem_wr    <= (st_nxt == ST_WR);
      bus_drive <= (st_nxt == ST_ACK) || (st_nxt == ST_WR);
      if (st == ST_ACK) begin
        mem_addr  <= addr;
        mem_wdata <= dev_data;
      end
    end
  end

  AST_ACK_GRANTED: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> bus_grant && bus_req); // R4
  AST_ACK_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> mem_wr && !dev_ack); // R4
  AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(dev_ack)); // R4
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !burst) |=> !bus_req); // R7
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && count_zero) |=> !bus_req); // R8
  AST_DRIVE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> bus_grant && (dev_ack || mem_wr)); // R12
  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && count_zero) |=> !bus_req); // R11

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_cs,
  input  logic [1:0]    cpu_rs,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_data,
  output logic          bus_drive,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          burst_q;
  logic          arm_q;
  logic          word_step;
  logic          xfer_end;
  logic          count_zero;

  assign count_zero = (count_q == '0);

  dma_regfile #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cpu_cs     (cpu_cs),
    .cpu_rs     (cpu_rs),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .bus_locked (bus_req),
    .word_step  (word_step),
    .xfer_end   (xfer_end),
    .addr_q     (addr_q),
    .count_q    (count_q),
    .burst_q    (burst_q),
    .arm_q      (arm_q),
    .irq_q      (irq)
  );

  dma_sequencer #(.DW(DW), .AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm_q),
    .burst      (burst_q),
    .count_zero (count_zero),
    .addr       (addr_q),
    .dev_req    (dev_req),
    .bus_grant  (bus_grant),
    .dev_data   (dev_data),
    .bus_req    (bus_req),
    .dev_ack    (dev_ack),
    .mem_wr     (mem_wr),
    .bus_drive  (bus_drive),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .word_step  (word_step),
    .xfer_end   (xfer_end)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !bus_req && !dev_ack && !mem_wr && !irq); // R1
  AST_IRQ_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !bus_req); // R8

endmodule

// File: tb/tb_dma_engine.sv
`timescale 1ns/100ps
module tb_dma_engine;

  localparam int DW = 16;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int WD_LIMIT = 50000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_cs = 1'b0;
  logic [1:0]    cpu_rs = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          irq;
  logic          bus_req;
  logic          bus_grant;
  logic          dev_req;
  logic          dev_ack;
  logic [DW-1:0] dev_data;
  logic          bus_drive;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wr;

  dma_engine #(.DW(DW), .AW(AW), .CW(CW)) dut (.*);

  always #2.5 clk = ~clk;

  // stimulus-side controls, written only by the initial block
  logic grant_en = 1'b1;
  int   p_total = 0;
  int   p_base  = 0;
  int   p_gen   = 0;

  // environment state, written only by the negedge block
  int   p_seen = 0;
  int   p_left = 0;
  int   p_idx  = 0;
  logic [DW-1:0] mem_img [0:63];
  int   wr_cnt = 0;
  int   req_rises = 0;
  int   drive_bad = 0;
  int   cyc = 0;
  int   last_wr_cyc = 0;
  int   irq_cyc = 0;
  logic prev_req = 1'b0;
  logic prev_irq = 1'b0;
  logic [DW-1:0] dev_data_r = '0;
  logic grant_r = 1'b0;
  int   wd_fail = 0;

  int   total = 0;
  int   fails = 0;

  assign dev_req   = (p_left != 0);
  assign dev_data  = dev_data_r;
  assign bus_grant = grant_r;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      for (int i = 0; i < 64; i++) mem_img[i] = '0;
      p_left = 0;
    end else begin
      if (p_gen != p_seen) begin
        p_seen = p_gen;
        p_left = p_total;
        p_idx  = 0;
      end else if (dev_ack && p_left > 0) begin
        dev_data_r = DW'(p_base + p_idx);
        p_idx  = p_idx + 1;
        p_left = p_left - 1;
      end
      if (mem_wr) begin
        mem_img[mem_addr[5:0]] = mem_wdata;
        wr_cnt = wr_cnt + 1;
        last_wr_cyc = cyc;
      end
      if (bus_req && !prev_req) req_rises = req_rises + 1;
      if (irq && !prev_irq) irq_cyc = cyc;
      if (bus_drive && !(bus_grant && (dev_ack || mem_wr))) drive_bad = drive_bad + 1;
    end
    prev_req = bus_req;
    prev_irq = irq;
    grant_r  = bus_req && grant_en;
  end

  always @(posedge clk) begin
    if (cyc == WD_LIMIT && wd_fail == 0) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] rs, input logic [DW-1:0] val);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_rs = rs; cpu_wdata = val;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] rs, output int val);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_rs = rs;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_rd = 1'b0;
    val = int'(cpu_rdata);
  endtask

  task automatic periph(input int n, input int base);
    @(negedge clk);
    p_total = n; p_base = base; p_gen = p_gen + 1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic program_ch(input int addr, input int cnt, input int mode);
    cpu_write(2'd1, DW'(cnt));
    cpu_write(2'd0, DW'(addr));
    cpu_write(2'd2, DW'(mode));
  endtask

  task automatic t_reset;
    int v;
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 dev_ack", int'(dev_ack), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    chk("R1 bus_drive", int'(bus_drive), 0);
    chk("R1 irq", int'(irq), 0);
    cpu_read(2'd0, v); chk("R1 addr", v, 0);
    cpu_read(2'd1, v); chk("R1 count", v, 0);
    cpu_read(2'd2, v); chk("R1 mode", v, 0);
  endtask

  task automatic t_regs;
    int v;
    cpu_write(2'd0, 16'h1234);
    cpu_write(2'd1, 16'h0007);
    cpu_write(2'd2, 16'h0001);
    cpu_read(2'd0, v); chk("R2 addr readback", v, 'h1234);
    cpu_read(2'd1, v); chk("R2 count readback", v, 7);
    cpu_read(2'd2, v); chk("R2 mode readback", v, 1);
    cpu_read(2'd3, v); chk("R2 status readback", v, 0);
  endtask

  task automatic t_zero_count;
    int r0;
    r0 = req_rises;
    program_ch(5, 0, 2);
    periph(2, 'h50);
    wait_cyc(10);
    chk("R11 no request on zero count", req_rises - r0, 0);
    chk("R11 bus_req low", int'(bus_req), 0);
    periph(0, 0);
    cpu_write(2'd2, 16'h0000);
  endtask

  task automatic t_grant_wait;
    int v, w0;
    w0 = wr_cnt;
    program_ch('h20, 1, 2);
    grant_en = 1'b0;
    periph(1, 'h100);
    wait_cyc(5);
    chk("R3 bus_req raised", int'(bus_req), 1);
    chk("R3 no ack without grant", int'(dev_ack), 0);
    chk("R3 no write without grant", wr_cnt - w0, 0);
    grant_en = 1'b1;
    wait_cyc(10);
    chk("R4 one word written", wr_cnt - w0, 1);
    chk("R4 word data at address", int'(mem_img['h20]), 'h100);
    chk("R8 irq raised", int'(irq), 1);
    chk("R8 bus released", int'(bus_req), 0);
    cpu_read(2'd0, v); chk("R5 address advanced", v, 'h21);
    cpu_read(2'd1, v); chk("R5 count exhausted", v, 0);
    cpu_read(2'd2, v); chk("R8 arm cleared", v, 0);
    cpu_read(2'd3, v); chk("R9 status shows irq", v, 2);
    wait_cyc(1);
    chk("R9 status read clears irq", int'(irq), 0);
  endtask

  task automatic t_burst;
    int r0, w0;
    r0 = req_rises; w0 = wr_cnt;
    program_ch('h08, 4, 3);
    periph(4, 'h200);
    wait_cyc(30);
    chk("R4 burst words", wr_cnt - w0, 4);
    for (int i = 0; i < 4; i++)
      chk("R4 burst data", int'(mem_img['h08 + i]), 'h200 + i);
    chk("R6 single request per burst", req_rises - r0, 1);
    chk("R8 irq after last write", irq_cyc - last_wr_cyc, 1);
    chk("R8 irq high", int'(irq), 1);
    cpu_write(2'd1, 16'h0000);
    wait_cyc(1);
    chk("R9 count write clears irq", int'(irq), 0);
  endtask

  task automatic t_steal;
    int r0, w0;
    r0 = req_rises; w0 = wr_cnt;
    program_ch('h30, 3, 2);
    periph(3, 'h300);
    wait_cyc(40);
    chk("R7 steal words", wr_cnt - w0, 3);
    for (int i = 0; i < 3; i++)
      chk("R7 steal data", int'(mem_img['h30 + i]), 'h300 + i);
    chk("R7 one request per word", req_rises - r0, 3);
    chk("R8 steal irq", int'(irq), 1);
    chk("R8 steal irq timing", irq_cyc - last_wr_cyc, 1);
    cpu_write(2'd1, 16'h0000);
  endtask

  task automatic t_burst_pause_lock;
    int v, r0, w0;
    r0 = req_rises; w0 = wr_cnt;
    program_ch('h18, 3, 3);
    periph(2, 'h400);
    wait_cyc(20);
    chk("R6 two words before pause", wr_cnt - w0, 2);
    chk("R6 bus held during pause", int'(bus_req), 1);
    chk("R6 no irq mid block", int'(irq), 0);
    cpu_write(2'd1, 16'h0009);
    cpu_write(2'd0, 16'h003F);
    periph(1, 'h402);
    wait_cyc(20);
    chk("R10 third word", wr_cnt - w0, 3);
    chk("R10 address kept under lock", int'(mem_img['h1A]), 'h402);
    chk("R10 stray address unused", int'(mem_img['h3F]), 0);
    chk("R6 one request across pause", req_rises - r0, 1);
    chk("R8 irq after paused burst", int'(irq), 1);
    cpu_read(2'd1, v); chk("R10 count not overwritten", v, 0);
    cpu_read(2'd0, v); chk("R5 address after block", v, 'h1B);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_zero_count();
    t_grant_wait();
    t_burst();
    t_steal();
    t_burst_pause_lock();
    chk("R12 drive only with grant", drive_bad, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule